// File: doc/BRIEF.md
# Prescaled Timer PWM Channel

A single pulse-width modulation channel built around a 16-bit up-counter. The counter is slowed by a 4-bit clock divider and compared against two programmable limits. The first limit ends the high part of each period. The second limit ends the period and returns the counter to zero. Software programs the channel through a word-addressed register window of four 32-bit locations. The window holds the live count, both limits and a control word.

The control word has separate enables for counting and for driving the output. A pulsed soft-reset bit stops the channel and zeroes its state before software reprograms it. A one-shot option runs exactly one period. An end-of-period event flag raises the interrupt line when it is unmasked. Because the count can be read and written, software can save a running channel and later restore it. One control bit is kept only as storage and has no effect.

Top module: `pwm_tmr`

## Requirements
- R1: After reset the count reads 0, both limits read 1, the control word reads 0, and pwm_out and irq are 0.
- R2: While run (control bit 0) is 1, the count advances by one once every (div+1) clocks, where div is control bits [12:9]. While run is 0, the count and the divider phase hold.
- R3: The count steps 0, 1, … and on the advance where count+1 reaches or passes the period limit (word 2) it returns to 0. That advance is the period end. A count loaded at or above the limit also returns to 0 on its next advance.
- R4: pwm_out is 1 exactly when run is 1, output enable (bit 3) is 1 and the count is below the high limit (word 1). Otherwise it is 0.
- R5: With one-shot (bit 4) set, run clears itself at the period end, so pwm_out then stays 0.
- R6: Each period end sets an event flag, and irq equals the flag AND interrupt enable (bit 5). A control write with bit 6 set clears the flag. A period end in the same cycle wins. Bit 6 always reads 0.
- R7: A control write with bit 7 set zeroes the count, the divider phase and the flag, and forces run and output enable to 0. Bit 7 reads 1 for the following cycle only.
- R8: A write to word 0 loads the count from data bits [15:0] and restarts the divider phase.
- R9: Limit writes keep data bits [15:0]. A written value of 0 is stored as 1. Bits [31:16] of every word read 0.
- R10: Word selection uses address bits [3:2] (0 count, 1 high limit, 2 period limit, 3 control). Any access with an address bit at or above bit 4 set is ignored on write and reads 0.
- R11: Control bit 8 is stored and read back but has no effect on counting or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, taken at the rising edge |
| reg_addr | input | ADDR_W | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_out | output | 1 | PWM waveform |
| irq | output | 1 | Interrupt request |

## Verification
Every register takes effect at the clock edge that samples the write, and reg_rdata, pwm_out and irq are combinational from registered state, so each result is due at the first edge after its stimulus. A divider advance shows div+1 edges after the divider phase restarts. The bench drives inputs just after each falling edge and compares every output at the next falling edge against a cycle-stepped model of the requirements. The directed cases count the edges explicitly, for example three edges from enable to the first advance with div=2, and three edges to the period end with a period limit of 3.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    localparam int DATA_W      = 32;
    localparam int CNT_W       = 16;
    localparam int PRE_W       = 4;
    localparam int STRIDE_LOG2 = 4;

    typedef enum logic [1:0] {
        W_COUNT = 2'd0,
        W_HREF  = 2'd1,
        W_LREF  = 2'd2,
        W_CTRL  = 2'd3
    } word_e;

    localparam int B_RUN     = 0;
    localparam int B_OE      = 3;
    localparam int B_ONESHOT = 4;
    localparam int B_IEN     = 5;
    localparam int B_ICLR    = 6;
    localparam int B_SRST    = 7;
    localparam int B_CAPT    = 8;
    localparam int B_DIV     = 9;

    typedef struct packed {
        logic [PRE_W-1:0] div;
        logic             capt;
        logic             srst;
        logic             ien;
        logic             oneshot;
        logic             oe;
        logic             run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(logic [DATA_W-1:0] w);
        ctrl_t c;
        c.run     = w[B_RUN] & ~w[B_SRST];
        c.oe      = w[B_OE] & ~w[B_SRST];
        c.oneshot = w[B_ONESHOT];
        c.ien     = w[B_IEN];
        c.srst    = w[B_SRST];
        c.capt    = w[B_CAPT];
        c.div     = w[B_DIV +: PRE_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w                 = '0;
        w[B_RUN]          = c.run;
        w[B_OE]           = c.oe;
        w[B_ONESHOT]      = c.oneshot;
        w[B_IEN]          = c.ien;
        w[B_SRST]         = c.srst;
        w[B_CAPT]         = c.capt;
        w[B_DIV +: PRE_W] = c.div;
        return w;
    endfunction

    function automatic logic [CNT_W-1:0] ref_clamp(logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
    parameter int PRE_W = pwm_tmr_pkg::PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = en && !restart && (phase_q >= div);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= tick ? '0 : phase_q + 1'b1;
        end
    end

    // R2: after an advance with a nonzero divisor the next clock cannot advance again
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div != $past(div)));

    // R2: the divider phase holds while counting is stopped
    a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!en && !restart) |=> $stable(phase_q));

endmodule

// File: rtl/pwm_tmr_count.sv
module pwm_tmr_count #(
    parameter int CNT_W = pwm_tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] lref,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap
);
    logic [CNT_W:0] cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign wrap    = tick && !clr && !load && (cnt_inc >= {1'b0, lref});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= wrap ? '0 : cnt_inc[CNT_W-1:0];
        end
    end

    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));

    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !clr && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

    a_r8_load_value: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  href_q,
    output logic [CNT_W-1:0]  lref_q,
    output logic              cnt_load,
    output logic              ctrl_wr,
    output logic              clr,
    output logic              flag_q
);
    logic  hit;
    word_e word;

    assign hit      = (reg_addr[ADDR_W-1:STRIDE_LOG2] == '0);
    assign word     = word_e'(reg_addr[STRIDE_LOG2-1:2]);
    assign cnt_load = reg_wr && hit && (word == W_COUNT);
    assign ctrl_wr  = reg_wr && hit && (word == W_CTRL);
    assign clr      = ctrl_wr && reg_wdata[B_SRST];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_from_word(reg_wdata);
        end else begin
            ctrl_q.srst <= 1'b0;
            if (wrap && ctrl_q.oneshot) begin
                ctrl_q.run <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            href_q <= CNT_W'(1);
            lref_q <= CNT_W'(1);
        end else if (reg_wr && hit) begin
            if (word == W_HREF) href_q <= ref_clamp(reg_wdata[CNT_W-1:0]);
            if (word == W_LREF) lref_q <= ref_clamp(reg_wdata[CNT_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flag_q <= 1'b0;
        end else if (wrap) begin
            flag_q <= 1'b1;
        end else if (ctrl_wr && reg_wdata[B_ICLR]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit) begin
            unique case (word)
                W_COUNT: reg_rdata = DATA_W'(cnt);
                W_HREF:  reg_rdata = DATA_W'(href_q);
                W_LREF:  reg_rdata = DATA_W'(lref_q);
                W_CTRL:  reg_rdata = ctrl_to_word(ctrl_q);
                default: reg_rdata = '0;
            endcase
        end
    end

    a_r7_srst_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.srst && !clr) |=> !ctrl_q.srst);

    a_r7_stops_channel: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!ctrl_q.run && !ctrl_q.oe && !flag_q && ctrl_q.srst));

    a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
        (wrap && ctrl_q.oneshot && !ctrl_wr) |=> !ctrl_q.run);

    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag_q);

    a_r9_refs_nonzero: assert property (@(posedge clk) disable iff (rst)
        (href_q != '0) && (lref_q != '0));

endmodule

// File: rtl/pwm_tmr.sv
module pwm_tmr
    import pwm_tmr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              pwm_out,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] href;
    logic [CNT_W-1:0] lref;
    logic [CNT_W-1:0] cnt;
    logic             cnt_load;
    logic             ctrl_wr;
    logic             clr;
    logic             flag;
    logic             tick;
    logic             wrap;

    pwm_tmr_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cnt       (cnt),
        .wrap      (wrap),
        .ctrl_q    (ctrl),
        .href_q    (href),
        .lref_q    (lref),
        .cnt_load  (cnt_load),
        .ctrl_wr   (ctrl_wr),
        .clr       (clr),
        .flag_q    (flag)
    );

    pwm_tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.run),
        .restart (clr || cnt_load),
        .div     (ctrl.div),
        .tick    (tick)
    );

    pwm_tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .load     (cnt_load),
        .load_val (reg_wdata[CNT_W-1:0]),
        .tick     (tick),
        .lref     (lref),
        .cnt_q    (cnt),
        .wrap     (wrap)
    );

    assign pwm_out = ctrl.run && ctrl.oe && (cnt < href);
    assign irq     = flag && ctrl.ien;

    a_r5_rests_low: assert property (@(posedge clk) disable iff (rst)
        (wrap && ctrl.oneshot && !ctrl_wr) |=> !pwm_out);

    a_r7_output_off: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!pwm_out && !irq));

endmodule

// File: tb/pwm_tmr_tb_top.sv
module pwm_tmr_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          pwm_out;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwm_tmr #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .irq(irq)
    );

    // cycle-stepped model built from the requirements
    logic [15:0] m_cnt, m_href, m_lref;
    logic [3:0]  m_phase, m_div;
    logic        m_run, m_oe, m_one, m_ien, m_srst, m_capt, m_flag;

    always @(posedge clk) begin
        logic hit, cw, clrv, ld, tk, pend;
        logic [1:0] w;
        if (rst) begin
            m_cnt = 0; m_href = 1; m_lref = 1; m_phase = 0; m_div = 0;
            m_run = 0; m_oe = 0; m_one = 0; m_ien = 0; m_srst = 0; m_capt = 0; m_flag = 0;
        end else begin
            hit  = (reg_addr[AW-1:4] == 0);
            w    = reg_addr[3:2];
            cw   = reg_wr && hit && w == 2'd3;
            clrv = cw && reg_wdata[7];
            ld   = reg_wr && hit && w == 2'd0;
            tk   = m_run && !clrv && !ld && (m_phase >= m_div);
            pend = tk && ({1'b0, m_cnt} + 17'd1 >= {1'b0, m_lref});
            if (clrv || ld) m_phase = 0;
            else if (m_run) m_phase = tk ? 4'd0 : m_phase + 4'd1;
            if (clrv) m_cnt = 0;
            else if (ld) m_cnt = reg_wdata[15:0];
            else if (tk) m_cnt = pend ? 16'd0 : m_cnt + 16'd1;
            if (reg_wr && hit && w == 2'd1) m_href = (reg_wdata[15:0] == 0) ? 16'd1 : reg_wdata[15:0];
            if (reg_wr && hit && w == 2'd2) m_lref = (reg_wdata[15:0] == 0) ? 16'd1 : reg_wdata[15:0];
            if (clrv) m_flag = 0;
            else if (pend) m_flag = 1;
            else if (cw && reg_wdata[6]) m_flag = 0;
            if (cw) begin
                m_run = reg_wdata[0] & ~reg_wdata[7];
                m_oe  = reg_wdata[3] & ~reg_wdata[7];
                m_one = reg_wdata[4]; m_ien = reg_wdata[5]; m_srst = reg_wdata[7];
                m_capt = reg_wdata[8]; m_div = reg_wdata[12:9];
            end else begin
                m_srst = 0;
                if (pend && m_one) m_run = 0;
            end
        end
    end

    function automatic logic [31:0] m_read(logic [AW-1:0] a);
        if (a[AW-1:4] != 0) return 32'd0;
        case (a[3:2])
            2'd0: return {16'd0, m_cnt};
            2'd1: return {16'd0, m_href};
            2'd2: return {16'd0, m_lref};
            default: return {19'd0, m_div, m_capt, m_srst, 1'b0, m_ien, m_one, m_oe, 2'b00, m_run};
        endcase
    endfunction

    function automatic string rd_tag(logic [AW-1:0] a);
        if (a[AW-1:4] != 0) return "R10";
        case (a[3:2])
            2'd0: return "R3";
            2'd3: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        chk("R4", {31'd0, pwm_out}, {31'd0, m_run & m_oe & (m_cnt < m_href)});
        chk("R6", {31'd0, irq}, {31'd0, m_flag & m_ien});
        chk(rd_tag(reg_addr), reg_rdata, m_read(reg_addr));
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        rdw(8'h00, d); chk("R1", d, 32'd0);
        rdw(8'h04, d); chk("R1", d, 32'd1);
        rdw(8'h08, d); chk("R1", d, 32'd1);
        rdw(8'h0C, d); chk("R1", d, 32'd0);
        chk("R1", {30'd0, pwm_out, irq}, 32'd0);
        // R9 clamp and width
        wr(8'h04, 32'h0000_0000); rdw(8'h04, d); chk("R9", d, 32'd1);
        wr(8'h08, 32'h0001_2345); rdw(8'h08, d); chk("R9", d, 32'h2345);
        // R10 out-of-window access
        wr(8'h10, 32'h5);  rdw(8'h10, d); chk("R10", d, 32'd0);
        rdw(8'h00, d); chk("R10", d, 32'd0);
        wr(8'h1C, 32'hFFFF); rdw(8'h0C, d); chk("R10", d, 32'd0);
        // R11 stored-only bit
        wr(8'h0C, 32'h100); repeat (4) cyc();
        rdw(8'h0C, d); chk("R11", d, 32'h100);
        rdw(8'h00, d); chk("R11", d, 32'd0);
        // R7 soft reset pulse
        wr(8'h0C, 32'h89); rdw(8'h0C, d); chk("R7", d, 32'h80);
        cyc(); rdw(8'h0C, d); chk("R7", d, 32'h0);
        // R2 divider 2: first advance three edges after enable
        wr(8'h08, 32'd100); wr(8'h04, 32'd50);
        wr(8'h0C, 32'h409);
        repeat (9) cyc();
        rdw(8'h00, d); chk("R2", d, 32'd3);
        chk("R4", {31'd0, pwm_out}, 32'd1);
        // R8 load restarts divider phase
        wr(8'h00, 32'h40); rdw(8'h00, d); chk("R8", d, 32'h40);
        repeat (3) cyc(); rdw(8'h00, d); chk("R8", d, 32'h41);
        chk("R4", {31'd0, pwm_out}, 32'd0);
        // R3 / R5 / R6 one-shot period of 3
        wr(8'h0C, 32'h80);
        wr(8'h08, 32'd3); wr(8'h04, 32'd1);
        wr(8'h0C, 32'h39);
        chk("R4", {31'd0, pwm_out}, 32'd1);
        cyc(); cyc(); rdw(8'h00, d); chk("R3", d, 32'd2);
        cyc(); rdw(8'h00, d); chk("R3", d, 32'd0);
        rdw(8'h0C, d); chk("R5", d, 32'h38);
        chk("R5", {31'd0, pwm_out}, 32'd0);
        chk("R6", {31'd0, irq}, 32'd1);
        wr(8'h0C, 32'h78);
        chk("R6", {31'd0, irq}, 32'd0);
        rdw(8'h0C, d); chk("R6", d, 32'h38);
        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            int sel;
            logic [31:0] v;
            sel = $urandom % 100;
            reg_addr = ($urandom % 10 == 0) ? AW'(8'h10 + 4 * ($urandom % 4)) : AW'(4 * ($urandom % 4));
            reg_wr = 1'b0;
            v = $urandom;
            if (sel < 10) begin
                reg_wr = 1'b1; reg_addr = 8'h0C;
                v[12:9] = 4'($urandom % 4);
                v[7] = ($urandom % 8 == 0);
                if ($urandom % 3 != 0) v[0] = 1'b1;
            end else if (sel < 14) begin
                reg_wr = 1'b1; reg_addr = 8'h00; v[15:0] = 16'($urandom % 16);
            end else if (sel < 18) begin
                reg_wr = 1'b1; reg_addr = 8'h04; v[15:0] = 16'($urandom % 16);
            end else if (sel < 22) begin
                reg_wr = 1'b1; reg_addr = 8'h08; v[15:0] = 16'($urandom % 16);
            end else if (sel < 24) begin
                reg_wr = 1'b1; reg_addr = AW'(8'h10 + 4 * ($urandom % 12));
            end
            reg_wdata = v;
            cyc();
        end
        reg_wr = 1'b0;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule